// File: doc/BRIEF.md
# Fine Phase-Shift Command Sequencer

This block sits in front of a direct digital synthesis core that has two frequency registers (a base one and an alternate one) and two phase registers of 12 bits. An upstream agent requests a phase shift as a 32-bit unsigned fraction of a full turn, together with a one-cycle strobe and the current base frequency word.

The sequencer splits the request into two terms:

- **Coarse term:** either zero or a half turn (2048 in phase-register units). It is applied through a phase register.
- **Fine term:** always below a half turn. It is applied by loading the alternate frequency register with base plus fine, then selecting that register for exactly one clock.

The coarse offset accumulates modulo 4096. Each request writes the new cumulative offset into whichever phase register is not in use. On the same clock as the one-cycle frequency pulse, the phase selection switches to that register and then stays there, so the coarse offset is always held.

A busy/done handshake tells the upstream agent when a new request can be accepted.

Top module: `phase_step_seq`

## Requirements
- R1: When bit 31 of the request is 0, the value written to the alternate frequency register equals base + request (mod 2^32), and the coarse term is 0.
- R2: When bit 31 of the request is 1, the written alternate frequency value equals base + request − 2^31 (mod 2^32), and the coarse term is 2048.
- R3: The fine term (written value minus base, mod 2^32) is always below 2^31.
- R4: The phase value written equals (previous cumulative offset + coarse term) mod 4096. It is written to the phase register index that is not currently selected (`phase_wr_idx` = NOT `phase_sel`). The offset starts at 0.
- R5: The frequency write and the phase write are both asserted in the single cycle after an accepted strobe. The select cycle follows on the next cycle.
- R6: `freq_sel` (1 = alternate register, 0 = base) is high for exactly one clock per request and then returns to 0.
- R7: `phase_sel` toggles on the same clock that `freq_sel` goes high, and holds its value at all other times.
- R8: `busy` is high for three cycles after an accepted strobe. `done` is a one-cycle pulse in the third of those cycles. A strobe seen while `busy` is high is ignored and starts no request.
- R9: After reset, `busy`, `done`, both write enables, `freq_sel` and `phase_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_strobe | input | 1 | Request strobe, sampled only when idle |
| req_turn | input | 32 | Requested shift as a fraction of a full turn |
| base_freq | input | 32 | Current base frequency tuning word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| freq_wr_en | output | 1 | Write enable for the alternate frequency register |
| freq_wr_data | output | 32 | Value for the alternate frequency register |
| phase_wr_en | output | 1 | Write enable for a phase register |
| phase_wr_idx | output | 1 | Index of the phase register being written |
| phase_wr_data | output | 12 | New cumulative coarse offset |
| freq_sel | output | 1 | 1 selects the alternate frequency register |
| phase_sel | output | 1 | Index of the selected phase register |

## Verification
If the cumulative offset register is wrong, it shows up at `phase_wr_data` on the very next request, and it stays wrong on every request after that. If the select tracker is wrong, `phase_wr_idx` equals `phase_sel` during the write cycle, or `phase_sel` fails to flip in the select cycle. Either fault is visible within two cycles of the strobe. A faulty sequence controller shows as `freq_sel` lasting other than one clock, or as a `done` pulse in the wrong cycle, within four cycles of the strobe.

// File: rtl/psq_pkg.sv
// Shared types for the phase-step sequencer.
// Assumes: a fixed four-step sequence per request.
package psq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SELECT = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/phase_splitter.sv
// Splits a turn fraction into a coarse half-turn term and a fine term,
// and forms the alternate frequency word as base + fine.
// Assumes: ACC_W-bit turn fraction, PH_W-bit phase registers.
module phase_splitter #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic [ACC_W-1:0] req_turn,
    input  logic [ACC_W-1:0] base_freq,
    output logic [ACC_W-1:0] alt_freq,
    output logic [PH_W-1:0]  coarse_term
);
    localparam logic [PH_W-1:0] HALF_PH = {1'b1, {(PH_W-1){1'b0}}};

    logic [ACC_W-1:0] fine_term;

    // Drop the half-turn bit into the coarse term; the remainder is the fine term.
    always_comb begin
        fine_term   = {1'b0, req_turn[ACC_W-2:0]};
        coarse_term = req_turn[ACC_W-1] ? HALF_PH : '0;
        alt_freq    = base_freq + fine_term;
    end
endmodule

// File: rtl/seq_fsm.sv
// Request sequencer: idle -> write -> select -> done -> idle.
// Assumes: strobes are honoured only in idle.
module seq_fsm
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_strobe,
    output seq_state_t state,
    output logic       accept
);
    seq_state_t state_d;

    // Accept a request only when idle.
    always_comb accept = (state == ST_IDLE) && req_strobe;

    // Next-state decode of the fixed sequence.
    always_comb begin
        unique case (state)
            ST_IDLE:   state_d = accept ? ST_WRITE : ST_IDLE;
            ST_WRITE:  state_d = ST_SELECT;
            ST_SELECT: state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // R6: the select state lasts one cycle.
    p_select_one_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT) |=> (state == ST_DONE));

    // R8: a strobe while busy starts nothing new.
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/coarse_tracker.sv
// Tracks the cumulative coarse offset (mod 2^PH_W) and which of the
// two phase registers is selected.
// Assumes: commit is high for exactly one cycle per request.
module coarse_tracker #(
    parameter int PH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [PH_W-1:0] coarse_term,
    output logic [PH_W-1:0] next_offset,
    output logic            phase_sel,
    output logic            wr_idx
);
    logic [PH_W-1:0] offset_q;

    // New offset wraps modulo the phase register range.
    always_comb begin
        next_offset = offset_q + coarse_term;
        wr_idx      = ~phase_sel;
    end

    // On commit, store the new offset and switch to the freshly written register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q  <= '0;
            phase_sel <= 1'b0;
        end else if (commit) begin
            offset_q  <= next_offset;
            phase_sel <= ~phase_sel;
        end
    end

    // R7: the selection holds unless a commit occurred.
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(phase_sel));
endmodule

// File: rtl/phase_step_seq.sv
// Top: accepts a turn-fraction request, writes alternate frequency and
// phase registers, then pulses the frequency select while switching the
// phase select, and finally reports done.
// Assumes: the core latches writes in the cycle they are presented.
module phase_step_seq
    import psq_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_strobe,
    input  logic [ACC_W-1:0] req_turn,
    input  logic [ACC_W-1:0] base_freq,
    output logic             busy,
    output logic             done,
    output logic             freq_wr_en,
    output logic [ACC_W-1:0] freq_wr_data,
    output logic             phase_wr_en,
    output logic             phase_wr_idx,
    output logic [PH_W-1:0]  phase_wr_data,
    output logic             freq_sel,
    output logic             phase_sel
);
    seq_state_t       state;
    logic             accept;
    logic [ACC_W-1:0] turn_q;
    logic [ACC_W-1:0] base_q;
    logic [PH_W-1:0]  coarse_term;
    logic [ACC_W-1:0] fine_chk;

    seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_strobe (req_strobe),
        .state      (state),
        .accept     (accept)
    );

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= '0;
            base_q <= '0;
        end else if (accept) begin
            turn_q <= req_turn;
            base_q <= base_freq;
        end
    end

    phase_splitter #(.ACC_W(ACC_W), .PH_W(PH_W)) u_split (
        .req_turn    (turn_q),
        .base_freq   (base_q),
        .alt_freq    (freq_wr_data),
        .coarse_term (coarse_term)
    );

    coarse_tracker #(.PH_W(PH_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (state == ST_WRITE),
        .coarse_term (coarse_term),
        .next_offset (phase_wr_data),
        .phase_sel   (phase_sel),
        .wr_idx      (phase_wr_idx)
    );

    // Decode the handshake and core controls from the sequence state.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        freq_wr_en  = (state == ST_WRITE);
        phase_wr_en = (state == ST_WRITE);
        freq_sel    = (state == ST_SELECT);
        fine_chk    = freq_wr_data - base_q;
    end

    // R3: the fine term stays below a half turn.
    p_fine_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freq_wr_en |-> !fine_chk[ACC_W-1]);

    // R5: the select cycle is preceded by the write cycle.
    p_write_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel |-> $past(freq_wr_en && phase_wr_en));

    // R6: the frequency select is a single-cycle pulse.
    p_fsel_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel |=> !freq_sel);

    // R7: the phase select flips on the same clock as the frequency pulse.
    p_same_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freq_sel) |-> (phase_sel != $past(phase_sel)));

    // R4: the write targets the register not in use.
    p_other_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_wr_en |-> (phase_wr_idx != phase_sel));
endmodule

// File: tb/phase_step_seq_bench.sv
module phase_step_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_strobe = 1'b0;
    logic [31:0] req_turn = '0;
    logic [31:0] base_freq = '0;
    logic        busy, done, freq_wr_en, phase_wr_en, phase_wr_idx, freq_sel, phase_sel;
    logic [31:0] freq_wr_data;
    logic [11:0] phase_wr_data;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    // Bench model state.
    logic [11:0] m_off = '0;
    logic        m_sel = 1'b0;

    phase_step_seq u_phase_step_seq (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .req_turn(req_turn),
        .base_freq(base_freq), .busy(busy), .done(done), .freq_wr_en(freq_wr_en),
        .freq_wr_data(freq_wr_data), .phase_wr_en(phase_wr_en),
        .phase_wr_idx(phase_wr_idx), .phase_wr_data(phase_wr_data),
        .freq_sel(freq_sel), .phase_sel(phase_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_alt(input logic [31:0] q, input logic [31:0] b);
        return q[31] ? (b + q - 32'h8000_0000) : (b + q);
    endfunction

    function automatic logic [11:0] exp_coarse(input logic [31:0] q);
        return q[31] ? 12'd2048 : 12'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // One request; optionally poke an extra strobe while busy.
    task automatic do_req(input logic [31:0] q, input logic [31:0] b, input bit poke);
        logic [11:0] new_off;
        logic [31:0] alt;
        alt     = exp_alt(q, b);
        new_off = m_off + exp_coarse(q);
        @(negedge clk);
        req_strobe = 1'b1; req_turn = q; base_freq = b;
        @(negedge clk);                 // write cycle
        req_strobe = poke; req_turn = ~q; base_freq = ~b;
        chk(busy && freq_wr_en && phase_wr_en && !freq_sel && !done, "R5 write cycle",
            {busy, freq_wr_en, phase_wr_en, freq_sel, done}, 5'b11100);
        chk(freq_wr_data == alt, q[31] ? "R2 alt freq" : "R1 alt freq", freq_wr_data, alt);
        chk((freq_wr_data - b) < 32'h8000_0000, "R3 fine range", freq_wr_data - b, 0);
        chk(phase_wr_data == new_off, "R4 phase data", phase_wr_data, new_off);
        chk(phase_wr_idx == ~m_sel, "R4 write index", phase_wr_idx, ~m_sel);
        @(negedge clk);                 // select cycle
        m_sel = ~m_sel; m_off = new_off;
        chk(freq_sel && busy, "R6 freq_sel pulse", freq_sel, 1);
        chk(phase_sel == m_sel, "R7 phase_sel switch", phase_sel, m_sel);
        @(negedge clk);                 // done cycle
        req_strobe = 1'b0;
        chk(done && busy && !freq_sel, "R8 done pulse", {done, busy, freq_sel}, 3'b110);
        chk(phase_sel == m_sel, "R7 phase_sel hold", phase_sel, m_sel);
        @(negedge clk);                 // back to idle
        chk(!busy && !done && !freq_wr_en && !freq_sel, "R8 idle, busy strobe ignored",
            {busy, done, freq_wr_en, freq_sel}, 0);
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1999);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !freq_wr_en && !phase_wr_en && !freq_sel && !phase_sel,
            "R9 reset state", {busy, done, freq_wr_en, phase_wr_en, freq_sel, phase_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !phase_sel, "R9 after reset release", {busy, phase_sel}, 0);
        // Directed corners.
        do_req(32'h0000_0000, 32'h0400_0000, 1'b0);
        do_req(32'h7FFF_FFFF, 32'h0400_0000, 1'b1);
        do_req(32'h8000_0000, 32'h0400_0000, 1'b0);
        do_req(32'hC000_0000, 32'h0400_0000, 1'b1);
        do_req(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        // Random mix.
        for (int i = 0; i < 40; i++) begin
            do_req($urandom, $urandom, 1'($urandom));
        end
        finish_run();
    end
endmodule